// File: doc/BRIEF.md
# Multi-PHY Cell-Available Status Responder

This block is the physical-layer side of the status handshake on a shared multi-PHY cell bus. It looks after four ports. Each port supplies two status bits. The transmit bit means the port can accept a whole cell. The receive bit means a whole cell is waiting. An ATM-layer master polls these bits by placing port addresses on a 5-bit transmit address bus and a 5-bit receive address bus. The block answers on cell-available lines. Each line has its own output enable, so that several devices can share a line.

A status-mode input selects how the answers are given:
- **Shared mode:** one polled port answers on a single line.
- **Direct mode:** each of the four lines carries its own port's status at all times, and no address decoding takes place.
- **Grouped mode:** a polled group address drives all four lines at once, one line per port. This lets a master sweep many devices inside one 53-cycle cell window.

A bus-mode input chooses one of two layouts:
- **Single bus (8 or 16 bits):** one address pair serves all four ports.
- **Dual 8-bit bus:** ports 0 and 1 answer only to the A address buses, and ports 2 and 3 answer only to the B address buses.

Each device takes its group number from a configuration field. Every answer is registered: an address and the status bits seen at one rising edge appear on the lines after that edge.

Top module: `clavResponder`

## Requirements
- R1: While rstN is low, all eight cell-available lines and all eight output enables are 0.
- R2: With statusMode = 2'b01 (direct), after each edge every output enable of both directions is 1 and line i carries the status of port i sampled at that edge; the addresses have no effect.
- R3: With statusMode = 2'b00 or 2'b11 (shared) and busMode = 2'b00, 2'b01 or 2'b11 (single bus), an A address whose upper three bits equal devGroup and whose lower two bits equal p drives line 0 after the edge with port p's status and enable 1; lines 1 to 3 stay disabled.
- R4: Address 31 matches nothing: after an edge where an address bus held 31, nothing driven by that bus is enabled, even when devGroup = 7.
- R5: An address whose upper three bits differ from devGroup leaves the lines it could drive with enable 0 and value 0 after the edge; every disabled line reads 0.
- R6: Shared mode with busMode = 2'b10 (dual): an A address answers on line 0 only for ports 0 and 1 (address bit 1 = 0), and a B address answers on line 1 only for ports 2 and 3 (address bit 1 = 1); A and B can both answer in the same cycle.
- R7: Grouped mode (statusMode = 2'b10) on a single bus: any matching non-null A address drives all four lines, with line i carrying port i's status, and the lower two address bits are ignored.
- R8: Grouped mode on the dual bus: a matching A address drives lines 0 and 1 with ports 0 and 1, and a matching B address drives lines 2 and 3 with ports 2 and 3, independently of each other.
- R9: The transmit and receive directions are independent: each direction's lines depend only on that direction's own addresses and status bits.
- R10: On a single bus the B address buses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| statusMode | input | 2 | 00/11 shared, 01 direct, 10 grouped |
| busMode | input | 2 | 00 single 8-bit, 01 single 16-bit, 10 dual 8-bit, 11 single |
| devGroup | input | 3 | Port group of this device |
| txRoom | input | 4 | Per-port transmit room status |
| rxReady | input | 4 | Per-port receive cell-ready status |
| txAddrA | input | 5 | Transmit poll address, bus A |
| txAddrB | input | 5 | Transmit poll address, bus B |
| rxAddrA | input | 5 | Receive poll address, bus A |
| rxAddrB | input | 5 | Receive poll address, bus B |
| txClav | output | 4 | Transmit cell-available lines |
| txClavOe | output | 4 | Output enables for txClav |
| rxClav | output | 4 | Receive cell-available lines |
| rxClavOe | output | 4 | Output enables for rxClav |

## Verification
In dual-bus mode a poll on bus A and a poll on bus B can land in the same cycle. Each must then drive only its own half of the lines, without disturbing the other half. The sweep provokes this by setting each B address to the A address with bit 1 flipped. In most cycles both buses therefore match the same group but pick ports on opposite halves. A second pairing offsets the receive address from the transmit address, which loads both directions in the same cycle. Each line's enable and value is compared against an arithmetic model of the requirements.

// File: rtl/clavPkg.sv
package clavPkg;
  localparam int LINES = 4;
  localparam int SEL_W = $clog2(LINES);

  typedef enum logic [1:0] {
    MODE_SHARED     = 2'b00,
    MODE_DIRECT     = 2'b01,
    MODE_GROUPED    = 2'b10,
    MODE_SHARED_ALT = 2'b11
  } statusMode_e;

  typedef enum logic [1:0] {
    BUS_SINGLE8  = 2'b00,
    BUS_SINGLE16 = 2'b01,
    BUS_DUAL8    = 2'b10,
    BUS_SPARE    = 2'b11
  } busMode_e;

  // strobes from the address decoder to the line registers
  typedef struct packed {
    logic [LINES-1:0]            lineEn;
    logic [LINES-1:0][SEL_W-1:0] lineSel;
  } lineStrobe_t;
endpackage

// File: rtl/clavCtrl.sv
module clavCtrl
  import clavPkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int GRP_W  = 3
) (
  input  statusMode_e       mode,
  input  busMode_e          bus,
  input  logic [GRP_W-1:0]  grp,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [ADDR_W-1:0] addrB,
  output lineStrobe_t       strb
);
  localparam int PORT_W = ADDR_W - GRP_W;
  localparam int HALF   = LINES / 2;
  localparam logic [ADDR_W-1:0] NULL_ADDR = {ADDR_W{1'b1}};

  logic hitA, hitB, dual;

  always_comb begin
    hitA = (addrA != NULL_ADDR) && (addrA[ADDR_W-1 -: GRP_W] == grp);
    hitB = (addrB != NULL_ADDR) && (addrB[ADDR_W-1 -: GRP_W] == grp);
    dual = (bus == BUS_DUAL8);
    strb = '0;
    case (mode)
      MODE_DIRECT: begin
        for (int i = 0; i < LINES; i++) begin
          strb.lineEn[i]  = 1'b1;
          strb.lineSel[i] = SEL_W'(i);
        end
      end
      MODE_GROUPED: begin
        for (int i = 0; i < LINES; i++) begin
          strb.lineEn[i]  = dual ? ((i < HALF) ? hitA : hitB) : hitA;
          strb.lineSel[i] = SEL_W'(i);
        end
      end
      default: begin
        if (!dual) begin
          strb.lineEn[0]  = hitA;
          strb.lineSel[0] = addrA[PORT_W-1:0];
        end else begin
          strb.lineEn[0]  = hitA && !addrA[PORT_W-1];
          strb.lineSel[0] = addrA[PORT_W-1:0];
          strb.lineEn[1]  = hitB && addrB[PORT_W-1];
          strb.lineSel[1] = addrB[PORT_W-1:0];
        end
      end
    endcase
  end
endmodule

// File: rtl/clavDatapath.sv
module clavDatapath
  import clavPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  lineStrobe_t      strb,
  input  logic [LINES-1:0] status,
  output logic [LINES-1:0] clav,
  output logic [LINES-1:0] clavOe
);
  for (genvar g = 0; g < LINES; g++) begin : gLine
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        clav[g]   <= 1'b0;
        clavOe[g] <= 1'b0;
      end else begin
        clav[g]   <= strb.lineEn[g] & status[strb.lineSel[g]];
        clavOe[g] <= strb.lineEn[g];
      end
    end
  end
endmodule

// File: rtl/clavResponder.sv
module clavResponder
  import clavPkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int GRP_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        statusMode,
  input  logic [1:0]        busMode,
  input  logic [GRP_W-1:0]  devGroup,
  input  logic [LINES-1:0]  txRoom,
  input  logic [LINES-1:0]  rxReady,
  input  logic [ADDR_W-1:0] txAddrA,
  input  logic [ADDR_W-1:0] txAddrB,
  input  logic [ADDR_W-1:0] rxAddrA,
  input  logic [ADDR_W-1:0] rxAddrB,
  output logic [LINES-1:0]  txClav,
  output logic [LINES-1:0]  txClavOe,
  output logic [LINES-1:0]  rxClav,
  output logic [LINES-1:0]  rxClavOe
);
  lineStrobe_t txStrb, rxStrb;
  statusMode_e modeE;
  busMode_e    busE;

  assign modeE = statusMode_e'(statusMode);
  assign busE  = busMode_e'(busMode);

  clavCtrl #(.ADDR_W(ADDR_W), .GRP_W(GRP_W)) uTxCtrl (
    .mode(modeE), .bus(busE), .grp(devGroup),
    .addrA(txAddrA), .addrB(txAddrB), .strb(txStrb));

  clavCtrl #(.ADDR_W(ADDR_W), .GRP_W(GRP_W)) uRxCtrl (
    .mode(modeE), .bus(busE), .grp(devGroup),
    .addrA(rxAddrA), .addrB(rxAddrB), .strb(rxStrb));

  clavDatapath uTxPath (
    .clk(clk), .rstN(rstN), .strb(txStrb), .status(txRoom),
    .clav(txClav), .clavOe(txClavOe));

  clavDatapath uRxPath (
    .clk(clk), .rstN(rstN), .strb(rxStrb), .status(rxReady),
    .clav(rxClav), .clavOe(rxClavOe));
endmodule

// File: rtl/clavChecker.sv
module clavChecker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] statusMode,
  input logic [1:0] busMode,
  input logic [2:0] devGroup,
  input logic [3:0] txRoom,
  input logic [3:0] rxReady,
  input logic [4:0] txAddrA,
  input logic [4:0] txAddrB,
  input logic [4:0] rxAddrA,
  input logic [4:0] rxAddrB,
  input logic [3:0] txClav,
  input logic [3:0] txClavOe,
  input logic [3:0] rxClav,
  input logic [3:0] rxClavOe
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |-> (txClavOe == 4'h0 && rxClavOe == 4'h0 && txClav == 4'h0 && rxClav == 4'h0));

  a_r2_direct_follow: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(statusMode) == 2'b01) |->
      (txClavOe == 4'hF && rxClavOe == 4'hF && txClav == $past(txRoom) && rxClav == $past(rxReady)));

  a_r3_shared_upper_idle: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ($past(statusMode) == 2'b00 || $past(statusMode) == 2'b11)) |->
      ($countones(txClavOe[3:2]) == 0 && $countones(rxClavOe[3:2]) == 0));

  a_r4_null_release: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(statusMode) != 2'b01 && $past(txAddrA) == 5'd31 && $past(txAddrB) == 5'd31)
      |-> (txClavOe == 4'h0));

  a_r5_disabled_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    ((txClav & ~txClavOe) == 4'h0 && (rxClav & ~rxClavOe) == 4'h0));

  a_r7_group_all_lines: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(statusMode) == 2'b10 && $past(busMode) != 2'b10 &&
     $past(txAddrA) != 5'd31 && $past(txAddrA[4:2]) == $past(devGroup))
      |-> (txClavOe == 4'hF && txClav == $past(txRoom)));
endmodule

bind clavResponder clavChecker uChk (.*);

// File: tb/clavResponder_test.sv
module clavResponder_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] statusMode = 2'b00;
  logic [1:0] busMode = 2'b00;
  logic [2:0] devGroup = 3'd0;
  logic [3:0] txRoom = 4'h0, rxReady = 4'h0;
  logic [4:0] txAddrA = 5'd31, txAddrB = 5'd31, rxAddrA = 5'd31, rxAddrB = 5'd31;
  logic [3:0] txClav, txClavOe, rxClav, rxClavOe;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  clavResponder uut (
    .clk(clk), .rstN(rstN), .statusMode(statusMode), .busMode(busMode),
    .devGroup(devGroup), .txRoom(txRoom), .rxReady(rxReady),
    .txAddrA(txAddrA), .txAddrB(txAddrB), .rxAddrA(rxAddrA), .rxAddrB(rxAddrB),
    .txClav(txClav), .txClavOe(txClavOe), .rxClav(rxClav), .rxClavOe(rxClavOe));

  // arithmetic model of the requirements
  function automatic void model(input logic [1:0] md, input logic [1:0] bm, input logic [2:0] grp,
                                input logic [4:0] aA, input logic [4:0] aB, input logic [3:0] st,
                                output logic [3:0] oe, output logic [3:0] cv);
    bit hA, hB, dual;
    hA = (aA != 5'd31) && (aA[4:2] == grp);
    hB = (aB != 5'd31) && (aB[4:2] == grp);
    dual = (bm == 2'b10);
    oe = 4'h0; cv = 4'h0;
    if (md == 2'b01) begin
      oe = 4'hF; cv = st;
    end else if (md == 2'b10) begin
      if (!dual) begin
        if (hA) begin oe = 4'hF; cv = st; end
      end else begin
        if (hA) begin oe[1:0] = 2'b11; cv[1:0] = st[1:0]; end
        if (hB) begin oe[3:2] = 2'b11; cv[3:2] = st[3:2]; end
      end
    end else begin
      if (!dual) begin
        if (hA) begin oe[0] = 1'b1; cv[0] = st[aA[1:0]]; end
      end else begin
        if (hA && !aA[1]) begin oe[0] = 1'b1; cv[0] = st[aA[1:0]]; end
        if (hB && aB[1])  begin oe[1] = 1'b1; cv[1] = st[aB[1:0]]; end
      end
    end
  endfunction

  function automatic string tagOf(input logic [1:0] md, input logic [1:0] bm, input logic [2:0] grp,
                                  input logic [4:0] aA);
    if (md == 2'b01) return "R2";
    if (aA == 5'd31) return "R4";
    if (aA[4:2] != grp) return "R5";
    if (md == 2'b10) return (bm == 2'b10) ? "R8" : "R7";
    return (bm == 2'b10) ? "R6" : "R3";
  endfunction

  task automatic cmp(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // drive at a negedge, check at the following negedge
  task automatic pollCycle(input logic [1:0] md, input logic [1:0] bm, input logic [2:0] grp,
                           input logic [4:0] tA, input logic [4:0] tB,
                           input logic [4:0] rA, input logic [4:0] rB,
                           input logic [3:0] tSt, input logic [3:0] rSt, input string tagOvr);
    logic [3:0] eTxOe, eTxCv, eRxOe, eRxCv;
    string tTag, rTag;
    statusMode = md; busMode = bm; devGroup = grp;
    txAddrA = tA; txAddrB = tB; rxAddrA = rA; rxAddrB = rB;
    txRoom = tSt; rxReady = rSt;
    model(md, bm, grp, tA, tB, tSt, eTxOe, eTxCv);
    model(md, bm, grp, rA, rB, rSt, eRxOe, eRxCv);
    tTag = (tagOvr != "") ? tagOvr : tagOf(md, bm, grp, tA);
    rTag = (tagOvr != "") ? tagOvr : tagOf(md, bm, grp, rA);
    @(negedge clk);
    cmp(tTag, "txClavOe", txClavOe, eTxOe);
    cmp(tTag, "txClav", txClav, eTxCv);
    cmp(rTag, "rxClavOe", rxClavOe, eRxOe);
    cmp(rTag, "rxClav", rxClav, eRxCv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] st;
    // R1: outputs quiet during reset, even with direct mode requested
    statusMode = 2'b01; txRoom = 4'hF; rxReady = 4'hF;
    repeat (3) @(negedge clk);
    cmp("R1", "txClavOe", txClavOe, 4'h0);
    cmp("R1", "rxClavOe", rxClavOe, 4'h0);
    cmp("R1", "txClav", txClav, 4'h0);
    cmp("R1", "rxClav", rxClav, 4'h0);
    rstN = 1'b1;

    // R10: single bus, only B matches -> no response
    pollCycle(2'b00, 2'b00, 3'd2, 5'd31, 5'd9, 5'd31, 5'd10, 4'hF, 4'hF, "R10");
    pollCycle(2'b10, 2'b01, 3'd2, 5'd4, 5'd8, 5'd31, 5'd8, 4'hF, 4'hF, "R10");
    // R9: tx polled, rx null, and the reverse
    pollCycle(2'b00, 2'b00, 3'd5, 5'd22, 5'd31, 5'd31, 5'd31, 4'h4, 4'hF, "R9");
    pollCycle(2'b00, 2'b00, 3'd5, 5'd31, 5'd31, 5'd21, 5'd31, 4'hF, 4'h2, "R9");
    // R4: null address with group 7 selected
    pollCycle(2'b10, 2'b00, 3'd7, 5'd31, 5'd31, 5'd31, 5'd31, 4'hF, 4'hF, "R4");

    // sweep: every mode, bus layout, several groups, every address
    for (int md = 0; md < 4; md++)
      for (int bm = 0; bm < 4; bm++)
        for (int gi = 0; gi < 3; gi++)
          for (int a = 0; a < 32; a++) begin
            logic [2:0] g;
            g = (gi == 0) ? 3'd0 : (gi == 1) ? 3'd5 : 3'd7;
            st = 4'(a * 7 + md * 3 + bm + gi * 5);
            pollCycle(2'(md), 2'(bm), g,
                      5'(a), 5'(a) ^ 5'b00010,
                      5'(a + 5), 5'(a + 5) ^ 5'b00010,
                      st, ~st, "");
          end

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule